// File: doc/BRIEF.md
# Masked Register Update Sequencer

This block changes a chosen subset of bits in one register that sits behind an indirect-access reconfiguration controller. The controller has no direct path to its target registers. A bus master must first program a channel selector and an access-mode word. It then loads a target offset, starts a transfer through a control/status word, and waits on a busy flag before it may use the data word. The sequencer hides all of that behind a single command.

A client presents a channel number, a target offset, a bit mask and the new bit values, then pulses start. The sequencer does the following, in order:

1. It programs the channel and selects manual access.
2. It runs an indirect read and polls busy until the fetched word is valid.
3. It merges the new bits into the fetched word under the mask.
4. It runs an indirect write of the merged word and polls busy again.
5. It reports completion together with the value written.

A poll that stays busy for too long ends the command with an error flag.

Top module: `rmw_seq`

## Requirements
- R1: After reset, cmd_ready is 1, done and err are 0, result is 0, and neither avm_read nor avm_write is asserted.
- R2: An accepted command first writes the channel number to the channel word (default 0x38), then the value 1 (manual access) to the mode word (0x3A), then the offset to the offset word (0x3B), then the value 0x2 (CSR bit 1, read start) to the CSR (0x3D).
- R3: After the read start, the CSR is read repeatedly until bit BUSY_BIT (default 8) is 0. Only then is the data word (0x3C) read. The same polling follows the write start, so each phase performs one more CSR read than the number of busy responses.
- R4: The write phase writes the offset to the offset word, then the merged value to the data word, then the value 0x1 (CSR bit 0, write start) to the CSR.
- R5: The merged value is (fetched & ~mask) | (bits & mask). Bits outside the mask keep their fetched value, and a zero mask writes back the fetched word unchanged.
- R6: When the final poll shows busy clear, done pulses for exactly one cycle with err = 0 and result equal to the merged value, and cmd_ready is 1 in that same cycle.
- R7: While avm_waitrequest is high during an access, avm_address, avm_writedata, avm_read and avm_write stay unchanged. Read data is taken in the cycle in which avm_waitrequest is low.
- R8: If POLL_LIMIT consecutive CSR reads all show busy, the command ends: done pulses with err = 1 and result = 0, and no further access is made.
- R9: A start pulse while a command is in progress is ignored. The running command's bus sequence, result and err are unaffected, and no other register changes.
- R10: avm_read and avm_write are never asserted together, and one access completes before the next begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse; taken only while cmd_ready is 1 |
| cmd_channel | input | CHAN_W | Logical channel to select |
| cmd_offset | input | OFFS_W | Target register offset |
| cmd_mask | input | DATA_W | Bits to be replaced |
| cmd_bits | input | DATA_W | New values for the masked bits |
| cmd_ready | output | 1 | Sequencer idle and able to accept a command |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout on the last command |
| result | output | DATA_W | Value written on success, 0 on timeout |
| avm_address | output | ADDR_W | Controller word address |
| avm_read | output | 1 | Read request |
| avm_write | output | 1 | Write request |
| avm_writedata | output | DATA_W | Write data |
| avm_readdata | input | DATA_W | Read data |
| avm_waitrequest | input | 1 | Controller stall |

## Verification
The hardest situation to reach is a poll timeout that arrives in the middle of a random bus stall pattern. The busy flag must stay set through exactly POLL_LIMIT reads, and each of those reads can itself be held off by waitrequest. The bench models the controller with a per-command count of busy responses. Setting that count far above a reduced POLL_LIMIT forces the timeout while pseudo-random waitrequest stalls keep running. The bench then counts the polls and confirms that no data-word access follows. A start pulse injected mid-command, with a different channel and offset, shows that the ignored command leaves no trace on the bus or in the modeled registers.

// File: rtl/rmw_seq_pkg.sv
package rmw_seq_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_CHAN,
    SQ_MODE,
    SQ_ROFS,
    SQ_RGO,
    SQ_RPOLL,
    SQ_FETCH,
    SQ_WOFS,
    SQ_WDAT,
    SQ_WGO,
    SQ_WPOLL
  } sq_state_e;

  localparam int unsigned MANUAL_MODE  = 1;
  localparam int unsigned CSR_WR_GO    = 0;
  localparam int unsigned CSR_RD_GO    = 1;

endpackage

// File: rtl/rmw_merge.sv
module rmw_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] bits,
  output logic [DATA_W-1:0] merged
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged[i] = mask[i] ? bits[i] : old_word[i];
  end

endmodule

// File: rtl/rmw_poll_timer.sv
module rmw_poll_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic last
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));

  // R8
  poll_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));

endmodule

// File: rtl/rmw_bus_port.sv
module rmw_bus_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_read,
  output logic              avm_write,
  output logic [DATA_W-1:0] avm_writedata,
  input  logic [DATA_W-1:0] avm_readdata,
  input  logic              avm_waitrequest
);

  logic active;
  assign active = avm_read | avm_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      avm_address   <= '0;
      avm_read      <= 1'b0;
      avm_write     <= 1'b0;
      avm_writedata <= '0;
      ack           <= 1'b0;
      rsp_data      <= '0;
    end else begin
      ack <= 1'b0;
      if (active) begin
        if (!avm_waitrequest) begin
          avm_read  <= 1'b0;
          avm_write <= 1'b0;
          ack       <= 1'b1;
          if (avm_read) rsp_data <= avm_readdata;
        end
      end else if (req) begin
        avm_address   <= req_addr;
        avm_writedata <= req_wdata;
        avm_write     <= req_we;
        avm_read      <= !req_we;
      end
    end
  end

  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(avm_read && avm_write));

  // R10
  req_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> !active);

  // R7
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (active && avm_waitrequest) |=> ($stable(avm_address) && $stable(avm_writedata)
                                     && $stable(avm_read) && $stable(avm_write)));

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_seq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CHAN_W     = 10,
  parameter int OFFS_W     = 16,
  parameter int POLL_LIMIT = 1024,
  parameter int BUSY_BIT   = 8,
  parameter logic [ADDR_W-1:0] CHAN_ADDR = 'h38,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h3A,
  parameter logic [ADDR_W-1:0] OFFS_ADDR = 'h3B,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h3C,
  parameter logic [ADDR_W-1:0] CSR_ADDR  = 'h3D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [CHAN_W-1:0] cmd_channel,
  input  logic [OFFS_W-1:0] cmd_offset,
  input  logic [DATA_W-1:0] cmd_mask,
  input  logic [DATA_W-1:0] cmd_bits,
  output logic              cmd_ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] result,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_read,
  output logic              avm_write,
  output logic [DATA_W-1:0] avm_writedata,
  input  logic [DATA_W-1:0] avm_readdata,
  input  logic              avm_waitrequest
);

  sq_state_e         state;
  logic              issued;
  logic [CHAN_W-1:0] ch_q;
  logic [OFFS_W-1:0] ofs_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] bits_q;
  logic [DATA_W-1:0] fetched_q;
  logic [DATA_W-1:0] merged;

  logic              acc_req;
  logic              acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic              acc_ack;
  logic [DATA_W-1:0] acc_rdata;

  logic              polling;
  logic              busy_seen;
  logic              tmr_clr;
  logic              tmr_tick;
  logic              tmr_last;

  assign cmd_ready = (state == SQ_IDLE);
  assign acc_req   = (state != SQ_IDLE) && !issued;
  assign polling   = (state == SQ_RPOLL) || (state == SQ_WPOLL);
  assign busy_seen = acc_rdata[BUSY_BIT];
  assign tmr_clr   = (state == SQ_RGO) || (state == SQ_WGO);
  assign tmr_tick  = acc_ack && polling && busy_seen && !tmr_last;

  rmw_merge #(.DATA_W(DATA_W)) merge_i (
    .old_word (fetched_q),
    .mask     (mask_q),
    .bits     (bits_q),
    .merged   (merged)
  );

  rmw_poll_timer #(.LIMIT(POLL_LIMIT)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (tmr_clr),
    .tick (tmr_tick),
    .last (tmr_last)
  );

  rmw_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
    .clk             (clk),
    .rst             (rst),
    .req             (acc_req),
    .req_we          (acc_we),
    .req_addr        (acc_addr),
    .req_wdata       (acc_wdata),
    .ack             (acc_ack),
    .rsp_data        (acc_rdata),
    .avm_address     (avm_address),
    .avm_read        (avm_read),
    .avm_write       (avm_write),
    .avm_writedata   (avm_writedata),
    .avm_readdata    (avm_readdata),
    .avm_waitrequest (avm_waitrequest)
  );

  // Access issued by each step of the sequence
  always_comb begin
    acc_we    = 1'b1;
    acc_addr  = CHAN_ADDR;
    acc_wdata = '0;
    unique case (state)
      SQ_CHAN: acc_wdata = DATA_W'(ch_q);
      SQ_MODE: begin
        acc_addr  = MODE_ADDR;
        acc_wdata = DATA_W'(MANUAL_MODE);
      end
      SQ_ROFS, SQ_WOFS: begin
        acc_addr  = OFFS_ADDR;
        acc_wdata = DATA_W'(ofs_q);
      end
      SQ_RGO: begin
        acc_addr             = CSR_ADDR;
        acc_wdata[CSR_RD_GO] = 1'b1;
      end
      SQ_RPOLL, SQ_WPOLL: begin
        acc_addr = CSR_ADDR;
        acc_we   = 1'b0;
      end
      SQ_FETCH: begin
        acc_addr = DATA_ADDR;
        acc_we   = 1'b0;
      end
      SQ_WDAT: begin
        acc_addr  = DATA_ADDR;
        acc_wdata = merged;
      end
      SQ_WGO: begin
        acc_addr             = CSR_ADDR;
        acc_wdata[CSR_WR_GO] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      issued    <= 1'b0;
      ch_q      <= '0;
      ofs_q     <= '0;
      mask_q    <= '0;
      bits_q    <= '0;
      fetched_q <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      result    <= '0;
    end else begin
      done <= 1'b0;
      if (acc_req) issued <= 1'b1;
      if (state == SQ_IDLE) begin
        if (cmd_start) begin
          ch_q   <= cmd_channel;
          ofs_q  <= cmd_offset;
          mask_q <= cmd_mask;
          bits_q <= cmd_bits;
          err    <= 1'b0;
          result <= '0;
          state  <= SQ_CHAN;
        end
      end else if (acc_ack) begin
        issued <= 1'b0;
        unique case (state)
          SQ_CHAN:  state <= SQ_MODE;
          SQ_MODE:  state <= SQ_ROFS;
          SQ_ROFS:  state <= SQ_RGO;
          SQ_RGO:   state <= SQ_RPOLL;
          SQ_FETCH: begin
            fetched_q <= acc_rdata;
            state     <= SQ_WOFS;
          end
          SQ_WOFS:  state <= SQ_WDAT;
          SQ_WDAT:  state <= SQ_WGO;
          SQ_WGO:   state <= SQ_WPOLL;
          SQ_RPOLL, SQ_WPOLL: begin
            if (!busy_seen) begin
              if (state == SQ_RPOLL) begin
                state <= SQ_FETCH;
              end else begin
                state  <= SQ_IDLE;
                done   <= 1'b1;
                result <= merged;
              end
            end else if (tmr_last) begin
              state <= SQ_IDLE;
              done  <= 1'b1;
              err   <= 1'b1;
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end

  // R9
  accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_ready) |=> !cmd_ready);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  timeout_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (result == '0));

  // R2
  mode_value_chk: assert property (@(posedge clk) disable iff (rst)
    (avm_write && avm_address == MODE_ADDR) |-> (avm_writedata == DATA_W'(MANUAL_MODE)));

  // R10
  no_access_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && !$past(cmd_ready)) |=> !(avm_read || avm_write));

endmodule

// File: tb/rmw_seq_tb_top.sv
module rmw_seq_tb_top;

  localparam int PL = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [9:0]  cmd_channel = '0;
  logic [15:0] cmd_offset = '0;
  logic [31:0] cmd_mask = '0;
  logic [31:0] cmd_bits = '0;
  logic        cmd_ready, done, err;
  logic [31:0] result;
  logic [7:0]  avm_address;
  logic        avm_read, avm_write;
  logic [31:0] avm_writedata;
  logic [31:0] avm_readdata = '0;
  logic        avm_waitrequest = 1'b0;

  always #2.5 clk = ~clk;

  rmw_seq #(.POLL_LIMIT(PL)) dut_i (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_channel(cmd_channel),
    .cmd_offset(cmd_offset), .cmd_mask(cmd_mask), .cmd_bits(cmd_bits),
    .cmd_ready(cmd_ready), .done(done), .err(err), .result(result),
    .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
    .avm_writedata(avm_writedata), .avm_readdata(avm_readdata),
    .avm_waitrequest(avm_waitrequest)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [7:0]  addr;
    bit          we;
    logic [31:0] data;
    string       tag;
  } xact_t;

  xact_t exp_q[$];

  // Controller model
  logic [31:0] xcvr [8][8];
  logic [2:0]  s_chan = '0;
  logic [2:0]  s_ofs = '0;
  logic [31:0] s_mode = '0;
  logic [31:0] s_data = '0;
  int          busy_left = 0;
  int          busy_cfg = 0;
  int          polls = 0;
  bit          stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0]  p_addr = '0;
  logic [31:0] p_wdata = '0;
  logic        p_rd = 1'b0, p_wr = 1'b0, p_hold = 1'b0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    avm_waitrequest = stall_en && (lfsr[1:0] == 2'b00);
    case (avm_address)
      8'h3C:   avm_readdata = s_data;
      8'h3D:   avm_readdata = (busy_left > 0) ? 32'h0000_0100 : 32'h0000_0000;
      default: avm_readdata = 32'h0;
    endcase
  end

  always @(posedge clk) begin
    // R7: hold while stalled
    if (!rst && p_hold)
      check(avm_address == p_addr && avm_writedata == p_wdata && avm_read == p_rd
            && avm_write == p_wr, "R7 hold", {24'h0, avm_address}, {24'h0, p_addr});
    p_hold  = (avm_read || avm_write) && avm_waitrequest;
    p_addr  = avm_address;
    p_wdata = avm_writedata;
    p_rd    = avm_read;
    p_wr    = avm_write;
    // R10
    if (!rst && avm_read && avm_write) check(1'b0, "R10 read+write", 32'h1, 32'h0);
    if (!rst && (avm_read || avm_write) && !avm_waitrequest) begin
      if (avm_read && avm_address == 8'h3D) begin
        polls++;
        if (busy_left > 0) busy_left--;
      end else begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected access", {24'h0, avm_address}, 32'h0);
        end else begin
          xact_t e;
          e = exp_q.pop_front();
          check(avm_address == e.addr && avm_write == e.we, {e.tag, " addr"},
                {23'h0, avm_write, avm_address}, {23'h0, e.we, e.addr});
          if (e.we) check(avm_writedata == e.data, {e.tag, " wdata"}, avm_writedata, e.data);
          else      check(avm_readdata == e.data, {e.tag, " rdata"}, avm_readdata, e.data);
        end
        if (avm_read && avm_address == 8'h3C)
          check(busy_left == 0, "R3 data read while busy", busy_left, 0);
        if (avm_write) begin
          case (avm_address)
            8'h38: s_chan = avm_writedata[2:0];
            8'h3A: s_mode = avm_writedata;
            8'h3B: s_ofs  = avm_writedata[2:0];
            8'h3C: s_data = avm_writedata;
            8'h3D: begin
              check(s_mode == 32'd1, "R2 mode before start", s_mode, 32'd1);
              if (avm_writedata[1]) s_data = xcvr[s_chan][s_ofs];
              if (avm_writedata[0]) xcvr[s_chan][s_ofs] = s_data;
              busy_left = busy_cfg;
            end
            default: ;
          endcase
        end
      end
    end
  end

  function automatic xact_t mk(input logic [7:0] a, input bit we, input logic [31:0] d, input string t);
    xact_t x;
    x.addr = a; x.we = we; x.data = d; x.tag = t;
    return x;
  endfunction

  task automatic run_cmd(input int ch, input int ofs, input logic [31:0] mask,
                         input logic [31:0] bits, input int busy, input bit tmo, input bit inject);
    logic [31:0] old, merged, side;
    old    = xcvr[ch][ofs];
    side   = xcvr[7][7];
    merged = (old & ~mask) | (bits & mask);
    exp_q.push_back(mk(8'h38, 1'b1, 32'(ch), "R2 chan"));
    exp_q.push_back(mk(8'h3A, 1'b1, 32'd1, "R2 mode"));
    exp_q.push_back(mk(8'h3B, 1'b1, 32'(ofs), "R2 offset"));
    exp_q.push_back(mk(8'h3D, 1'b1, 32'h2, "R2 read go"));
    if (!tmo) begin
      exp_q.push_back(mk(8'h3C, 1'b0, old, "R3 fetch"));
      exp_q.push_back(mk(8'h3B, 1'b1, 32'(ofs), "R4 offset"));
      exp_q.push_back(mk(8'h3C, 1'b1, merged, "R4 R5 merged"));
      exp_q.push_back(mk(8'h3D, 1'b1, 32'h1, "R4 write go"));
    end
    busy_cfg  = busy;
    busy_left = 0;
    polls     = 0;
    @(negedge clk);
    cmd_channel = 10'(ch);
    cmd_offset  = 16'(ofs);
    cmd_mask    = mask;
    cmd_bits    = bits;
    cmd_start   = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check(!cmd_ready, "R9 accepted", {31'h0, cmd_ready}, 32'h0);
    if (inject) begin
      repeat (4) @(negedge clk);
      cmd_channel = 10'd7;
      cmd_offset  = 16'd7;
      cmd_mask    = 32'hFFFF_FFFF;
      cmd_bits    = 32'h0;
      cmd_start   = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(err == tmo, tmo ? "R8 err" : "R6 err", {31'h0, err}, {31'h0, tmo});
    check(result == (tmo ? 32'h0 : merged), tmo ? "R8 result" : "R6 result", result,
          tmo ? 32'h0 : merged);
    check(cmd_ready, "R6 ready with done", {31'h0, cmd_ready}, 32'h1);
    if (tmo) begin
      check(polls == PL, "R8 poll count", polls, PL);
      check(xcvr[ch][ofs] == old, "R8 target untouched", xcvr[ch][ofs], old);
    end else begin
      check(polls == 2 * (busy + 1), "R3 poll count", polls, 2 * (busy + 1));
      check(xcvr[ch][ofs] == merged, "R5 target value", xcvr[ch][ofs], merged);
    end
    @(negedge clk);
    check(!done, "R6 done one cycle", {31'h0, done}, 32'h0);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2 sequence complete", exp_q.size(), 0);
    if (inject && !(ch == 7 && ofs == 7))
      check(xcvr[7][7] == side, "R9 other register", xcvr[7][7], side);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++)
      for (int o = 0; o < 8; o++)
        xcvr[c][o] = 32'hA55A_0F0F ^ (32'(c * 8 + o) * 32'h0101_0101);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1
    check(cmd_ready && !done && !err && result == 0 && !avm_read && !avm_write,
          "R1 reset state", {cmd_ready, done, err, avm_read, avm_write, 27'h0}, 32'h8000_0000);
    run_cmd(2, 3, 32'h0000_FF00, 32'h1234_5678, 0, 1'b0, 1'b0);
    stall_en = 1'b1;
    run_cmd(5, 1, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 3, 1'b0, 1'b0);
    run_cmd(1, 6, 32'h0000_0000, 32'hFFFF_FFFF, 1, 1'b0, 1'b0);
    run_cmd(4, 4, 32'hF0F0_000F, 32'h0A0A_5555, 2, 1'b0, 1'b1);
    run_cmd(3, 2, 32'h0000_00FF, 32'h0000_0011, 100, 1'b1, 1'b0);
    run_cmd(3, 2, 32'h8000_0001, 32'hFFFF_FFFF, 0, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule